// File: doc/BRIEF.md
# Upper-Memory Region Space Decoder

This block steers each CPU memory access in the legacy area between 640 Kbytes and 1 Mbyte to one of four target spaces: the on-chip display SRAM, the local/ISA bus, the boot ROM chip select, or DRAM. A small set of configuration registers controls the mapping. These registers hold a video enable, a monochrome-graphics placement select, a global DRAM enable, one ROM-select enable per 64-Kbyte block, and one DRAM-shadow enable per 16-Kbyte page of the option-ROM area. The registers are loaded through a simple write port.

The decode is combinational from the address and the registered configuration. The address passes through unchanged. The block also publishes a vector with one bit per 16-Kbyte page of A0000–FFFFF. Each bit shows whether that page currently defaults to the local/ISA bus, so a downstream window translator knows which pages it may claim. When ROM and DRAM shadow enables overlap, the ROM enable wins. Turning on DRAM globally never claims any part of the upper area.

Top module: `umr_space_decoder`

## Requirements
- R1: `space_onehot` always has exactly one bit set. The bits mean: bit 0 display SRAM, bit 1 local/ISA bus, bit 2 ROM chip select, bit 3 DRAM.
- R2: Register writes take effect at the clock edge where `cfg_we` is high. Index 0 holds control: bit 0 video enable, bit 1 monochrome placement, bit 2 global DRAM enable. Index 1 holds ROM enables in bits 4:0. Index 2 holds shadow enables in bits 15:0. A write to index 3 changes nothing. Synchronous reset clears every register, so every address then decodes to the local/ISA bus.
- R3: An address below A0000 or at 100000 and above goes to DRAM when the global DRAM enable is set, and to the local/ISA bus otherwise.
- R4: The global DRAM enable has no effect on any address in A0000–FFFFF.
- R5: With video enabled and monochrome placement off, B8000–BFFFF goes to display SRAM and B0000–B7FFF goes to the local/ISA bus.
- R6: With video enabled and monochrome placement on, B0000–B7FFF goes to display SRAM and B8000–BFFFF goes to the local/ISA bus.
- R7: With video disabled, all of B0000–BFFFF goes to the local/ISA bus, whatever the placement bit says.
- R8: ROM enable bit 0 routes A0000–AFFFF to ROM. Bits 1 to 4 route the 64-Kbyte blocks C0000, D0000, E0000 and F0000 to ROM.
- R9: Shadow bit i routes the page at C0000 + i×4000h to DRAM, but only when the ROM enable of its 64-Kbyte block is clear. A set ROM enable overrides it.
- R10: An address in A0000–FFFFF that matches no enabled mapping goes to the local/ISA bus.
- R11: Bit p of `page_bus_dflt` is set exactly when the page at A0000 + p×4000h (p = 0..23) currently decodes to the local/ISA bus.
- R12: `mem_addr` always equals `cpu_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 16 | Register write data |
| cpu_addr | input | 24 | CPU memory address |
| space_onehot | output | 4 | One-hot target space select |
| mem_addr | output | 24 | Address passed through untranslated |
| page_bus_dflt | output | 24 | Per-page flag: page defaults to local/ISA bus |

## Verification
The bench targets these corner cases:
- The edges of the display window in both placements, and with video off. A design that ignored the video enable or swapped the two placements would route the wrong half of B0000–BFFFF to SRAM.
- A page whose shadow bit and ROM block bit are both set. A design that got the priority wrong would send it to DRAM instead of ROM.
- The global DRAM enable, which must route the low and high areas to DRAM but none of A0000–FFFFF. A design that let it leak would claim the upper area.
- A write to the unused index, which would corrupt a mapping if it aliased onto another register.

Randomized configurations sweep the page-default vector against the per-address decode, to catch an off-by-one page index.

// File: rtl/umr_pkg.sv
package umr_pkg;

    localparam int ADDR_W       = 24;
    localparam int PAGE_W       = 14;                 // 16-Kbyte page
    localparam int PG_NUM_W     = ADDR_W - PAGE_W;
    localparam int BLK_PAGES    = 4;                  // pages per 64-Kbyte block
    localparam int UPPER_BASE   = 'hA0000 >> PAGE_W;  // first upper page
    localparam int MONO_FIRST   = 'hB0000 >> PAGE_W;
    localparam int COLOR_FIRST  = 'hB8000 >> PAGE_W;
    localparam int OPT_FIRST    = 'hC0000 >> PAGE_W;
    localparam int UPPER_END    = 'h100000 >> PAGE_W;
    localparam int UPPER_PAGES  = UPPER_END - UPPER_BASE;
    localparam int SHADOW_PAGES = UPPER_END - OPT_FIRST;
    localparam int ROM_BLOCKS   = 1 + SHADOW_PAGES / BLK_PAGES;
    localparam int PIDX_W       = $clog2(UPPER_PAGES);

    localparam int CFG_AW = 2;
    localparam int CFG_DW = 16;
    localparam logic [CFG_AW-1:0] REG_CTRL   = 2'd0;
    localparam logic [CFG_AW-1:0] REG_ROM    = 2'd1;
    localparam logic [CFG_AW-1:0] REG_SHADOW = 2'd2;

    typedef enum logic [1:0] {
        SP_DISPLAY = 2'd0,
        SP_BUS     = 2'd1,
        SP_ROM     = 2'd2,
        SP_DRAM    = 2'd3
    } space_e;

    typedef struct packed {
        logic                    video_en;
        logic                    mono;
        logic                    dram_en;
        logic [ROM_BLOCKS-1:0]   rom_en;
        logic [SHADOW_PAGES-1:0] shadow_en;
    } map_cfg_t;

    function automatic logic [3:0] space_to_onehot(space_e s);
        return 4'b0001 << s;
    endfunction

endpackage

// File: rtl/umr_cfg_regs.sv
module umr_cfg_regs
    import umr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output map_cfg_t          cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    cfg_q.video_en <= cfg_wdata[0];
                    cfg_q.mono     <= cfg_wdata[1];
                    cfg_q.dram_en  <= cfg_wdata[2];
                end
                REG_ROM:    cfg_q.rom_en    <= cfg_wdata[ROM_BLOCKS-1:0];
                REG_SHADOW: cfg_q.shadow_en <= cfg_wdata[SHADOW_PAGES-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/umr_page_map.sv
module umr_page_map
    import umr_pkg::*;
(
    input  logic                    video_en,
    input  logic                    mono,
    input  logic [ROM_BLOCKS-1:0]   rom_en,
    input  logic [SHADOW_PAGES-1:0] shadow_en,
    output space_e [UPPER_PAGES-1:0] page_space
);

    for (genvar g = 0; g < UPPER_PAGES; g++) begin : g_page
        localparam int ABS = UPPER_BASE + g;
        if (ABS < MONO_FIRST) begin : g_vga_area
            assign page_space[g] = rom_en[0] ? SP_ROM : SP_BUS;
        end else if (ABS < COLOR_FIRST) begin : g_mono_area
            assign page_space[g] = (video_en && mono) ? SP_DISPLAY : SP_BUS;
        end else if (ABS < OPT_FIRST) begin : g_color_area
            assign page_space[g] = (video_en && !mono) ? SP_DISPLAY : SP_BUS;
        end else begin : g_opt_area
            localparam int SH  = ABS - OPT_FIRST;
            localparam int BLK = 1 + SH / BLK_PAGES;
            assign page_space[g] = rom_en[BLK]    ? SP_ROM  :
                                   shadow_en[SH]  ? SP_DRAM : SP_BUS;
        end
    end

endmodule

// File: rtl/umr_space_decoder.sv
module umr_space_decoder
    import umr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    input  logic [ADDR_W-1:0]      cpu_addr,
    output logic [3:0]             space_onehot,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [UPPER_PAGES-1:0] page_bus_dflt
);

    map_cfg_t                 cfg;
    space_e [UPPER_PAGES-1:0] page_space;
    logic [PG_NUM_W-1:0]      rel_full;
    logic [PIDX_W-1:0]        rel_pg;
    logic                     in_upper;
    space_e                   sel;

    umr_cfg_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg)
    );

    umr_page_map map_i (
        .video_en   (cfg.video_en),
        .mono       (cfg.mono),
        .rom_en     (cfg.rom_en),
        .shadow_en  (cfg.shadow_en),
        .page_space (page_space)
    );

    // Page number relative to A0000; addresses below wrap to large values.
    assign rel_full = cpu_addr[ADDR_W-1:PAGE_W] - PG_NUM_W'(UPPER_BASE);
    assign rel_pg   = rel_full[PIDX_W-1:0];
    assign in_upper = rel_full < PG_NUM_W'(UPPER_PAGES);

    always_comb begin
        if (in_upper) sel = page_space[rel_pg];
        else          sel = cfg.dram_en ? SP_DRAM : SP_BUS;
    end

    assign space_onehot = space_to_onehot(sel);
    assign mem_addr     = cpu_addr;

    for (genvar p = 0; p < UPPER_PAGES; p++) begin : g_dflt
        assign page_bus_dflt[p] = (page_space[p] == SP_BUS);
    end

endmodule

// File: rtl/umr_space_checker.sv
module umr_space_checker
    import umr_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_we,
    input logic [CFG_AW-1:0]      cfg_addr,
    input logic [CFG_DW-1:0]      cfg_wdata,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic [3:0]             space_onehot,
    input logic [UPPER_PAGES-1:0] page_bus_dflt,
    input map_cfg_t               cfg
);

    logic             in_up;
    logic             in_opt;
    logic             in_b;
    logic [PIDX_W-1:0] pidx;
    logic [2:0]       blk;

    assign in_up  = cpu_addr >= 24'hA0000 && cpu_addr < 24'h100000;
    assign in_opt = cpu_addr >= 24'hC0000 && cpu_addr < 24'h100000;
    assign in_b   = cpu_addr >= 24'hB0000 && cpu_addr < 24'hC0000;
    assign pidx   = PIDX_W'((cpu_addr - 24'hA0000) >> PAGE_W);
    assign blk    = 3'd1 + {1'b0, cpu_addr[17:16]};

    AST_SPACE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(space_onehot) == 1);                                   // R1

    AST_ROM_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == REG_ROM) |=>
            cfg.rom_en == $past(cfg_wdata[ROM_BLOCKS-1:0]));              // R2

    AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (rst)
        (!in_up && cfg.dram_en) |-> space_onehot == 4'b1000);             // R3

    AST_VIDEO_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
        (in_b && !cfg.video_en) |-> space_onehot == 4'b0010);             // R7

    AST_ROM_OVER_SHADOW: assert property (@(posedge clk) disable iff (rst)
        (in_opt && cfg.rom_en[blk]) |-> space_onehot == 4'b0100);         // R9

    AST_PAGE_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        in_up |-> page_bus_dflt[pidx] == space_onehot[1]);                // R11

endmodule

bind umr_space_decoder umr_space_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .cpu_addr      (cpu_addr),
    .space_onehot  (space_onehot),
    .page_bus_dflt (page_bus_dflt),
    .cfg           (cfg)
);

// File: tb/umr_space_decoder_tb.sv
module umr_space_decoder_tb_top;

    // 4-unit period: one unit stands for 1 ns, giving 250 MHz.
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [23:0] cpu_addr = '0;
    logic [3:0]  space_onehot;
    logic [23:0] mem_addr;
    logic [23:0] page_bus_dflt;

    always #2 clk = ~clk;

    umr_space_decoder dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cpu_addr      (cpu_addr),
        .space_onehot  (space_onehot),
        .mem_addr      (mem_addr),
        .page_bus_dflt (page_bus_dflt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model of the configuration, from the requirements.
    bit        m_video, m_mono, m_dram;
    bit [4:0]  m_rom;
    bit [15:0] m_shadow;

    logic [23:0] addr_q[$];
    logic [3:0]  sel_q[$];
    logic [23:0] pg_q[$];
    string       tag_q[$];

    function automatic logic [3:0] model_sel(logic [23:0] a);
        int off;
        if (a < 24'hA0000 || a >= 24'h100000) return m_dram ? 4'b1000 : 4'b0010;
        if (a < 24'hB0000) return m_rom[0] ? 4'b0100 : 4'b0010;
        if (a < 24'hB8000) return (m_video && m_mono) ? 4'b0001 : 4'b0010;
        if (a < 24'hC0000) return (m_video && !m_mono) ? 4'b0001 : 4'b0010;
        off = int'(a - 24'hC0000);
        if (m_rom[1 + (off >> 16)]) return 4'b0100;
        if (m_shadow[off >> 14])    return 4'b1000;
        return 4'b0010;
    endfunction

    function automatic logic [23:0] model_pages();
        logic [23:0] v;
        for (int p = 0; p < 24; p++)
            v[p] = (model_sel(24'hA0000 + 24'(p) * 24'h4000) == 4'b0010);
        return v;
    endfunction

    task automatic wr(input logic [1:0] idx, input logic [15:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
        case (idx)
            2'd0: begin m_video = d[0]; m_mono = d[1]; m_dram = d[2]; end
            2'd1: m_rom = d[4:0];
            2'd2: m_shadow = d;
            default: ;
        endcase
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic chk(input logic [23:0] a, input string tag);
        @(posedge clk); #1;
        cpu_addr = a;
        addr_q.push_back(a);
        sel_q.push_back(model_sel(a));
        pg_q.push_back(model_pages());
        tag_q.push_back(tag);
    endtask

    // Monitor: compares at the falling edge, one item per cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (sel_q.size() > 0) begin
                logic [23:0] a, pe;
                logic [3:0]  se;
                string       t;
                a = addr_q.pop_front(); se = sel_q.pop_front();
                pe = pg_q.pop_front();  t = tag_q.pop_front();
                checks++;
                if (space_onehot !== se) begin
                    fails++;
                    $display("FAIL %s addr=%h space actual=%b expected=%b", t, a, space_onehot, se);
                end
                checks++;
                if (page_bus_dflt !== pe) begin
                    fails++;
                    $display("FAIL R11 addr=%h pages actual=%h expected=%h", a, page_bus_dflt, pe);
                end
                checks++;
                if (mem_addr !== a) begin
                    fails++;
                    $display("FAIL R12 mem_addr actual=%h expected=%h", mem_addr, a);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2: reset state, all bus
        chk(24'h050000, "R2");
        chk(24'h0F0000, "R2");
        chk(24'h0B8000, "R2");

        // R3 / R4: global DRAM enable only
        wr(2'd0, 16'h0004);
        chk(24'h000000, "R3");
        chk(24'h09FFFF, "R3");
        chk(24'h123456, "R3");
        chk(24'h0A0000, "R4");
        chk(24'h0C4000, "R4");
        chk(24'h0FFFFF, "R4");

        // R5: colour placement
        wr(2'd0, 16'h0005);
        chk(24'h0B8000, "R5");
        chk(24'h0BFFFF, "R5");
        chk(24'h0B0000, "R5");

        // R6: monochrome placement
        wr(2'd0, 16'h0007);
        chk(24'h0B0000, "R6");
        chk(24'h0B7FFF, "R6");
        chk(24'h0B8000, "R6");

        // R7: video off with mono bit set
        wr(2'd0, 16'h0006);
        chk(24'h0B0000, "R7");
        chk(24'h0BC000, "R7");

        // R2: index 3 write is ignored
        wr(2'd3, 16'hFFFF);
        chk(24'h0A0000, "R2");
        chk(24'h0C0000, "R2");
        chk(24'h0B8000, "R2");

        // R8: ROM blocks A and F
        wr(2'd1, 16'h0011);
        chk(24'h0A8000, "R8");
        chk(24'h0F0000, "R8");
        chk(24'h0E0000, "R10");
        chk(24'h0D0000, "R10");

        // R9: shadow pages with ROM priority
        wr(2'd2, 16'hF00F);
        chk(24'h0C0000, "R9");
        chk(24'h0CFFFF, "R9");
        chk(24'h0F4000, "R9");
        chk(24'h0D4000, "R10");
        wr(2'd1, 16'h0001);
        chk(24'h0F4000, "R9");
        chk(24'h0FC000, "R9");
        wr(2'd2, 16'h0020);
        chk(24'h0D4000, "R9");
        chk(24'h0D0000, "R10");

        // R11: random configurations and addresses
        for (int i = 0; i < 40; i++) begin
            wr(2'd0, 16'($urandom & 7));
            wr(2'd1, 16'($urandom & 31));
            wr(2'd2, 16'($urandom));
            for (int j = 0; j < 30; j++) begin
                if (j % 3 == 0) chk(24'($urandom), "R11");
                else            chk(24'hA0000 + 24'($urandom % 32'h60000), "R11");
            end
        end

        repeat (4) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule